// File: doc/BRIEF.md
# Monochrome LCD Panel Timing Generator

This block scans a 240 x 160, 1-bit-per-pixel passive monochrome panel from one of two frame buffers held in an external byte-wide RAM. Each RAM byte holds one group of four horizontally adjacent pixels. The block fetches the groups in raster order, leftmost group first, and presents one group per pixel clock on a 4-bit data bus. It also produces a free-running pixel clock, a line-latch pulse, a frame-start pulse one line long, and a polarity signal that flips once per frame.

The block runs from a base clock at twice the pixel rate. Each pixel period therefore has a high half and a low half, and the sync outputs can move in the low half only. A writer fills one buffer while the other is displayed. The buffer choice on `buf_sel_i` is taken once per frame, so a new buffer is always shown from its first line.

The panel side has no back-pressure. The data stream never stalls and the RAM must return a byte one base cycle after each address. A valid/ready handshake would have nothing to act on, so the block has none.

Top module: `lcd_mono_tgen`

## Requirements
- R1: While `rst` is high, and in the base cycle right after it falls, every panel output (`pclk_o`, `data_o`, `hs_o`, `vs_o`, `fr_o`) and `disp_buf_o` is 0, and `rd_addr_o` is 1.
- R2: From the first base edge after reset on, the scan is a stream of pixel periods of two base cycles each: 60 periods per line, 160 lines per frame, no blanking. `pclk_o` is high in the first base cycle of each period and low in the second.
- R3: In the period for line L, group C of a frame shown from buffer B, `data_o` equals bits [3:0] of the RAM byte at address B*9600 + L*60 + C (bits [7:4] when `PIX_HI` is 1). Bit 3 is the leftmost pixel. `data_o` changes only while `pclk_o` is high. The very first period after reset shows 0.
- R4: `rd_addr_o` is stable for a whole period and holds the address of the group shown in the next period. The byte at that address is expected on `rd_data_i` one base cycle after the address appears.
- R5: `hs_o` is high for exactly one base cycle per line: the low half of the line's last period (group 59).
- R6: `vs_o` is high for 120 base cycles per frame. It rises in the low half of the first period of line 0 and falls in the low half of the first period of line 1. It changes only while `pclk_o` is low.
- R7: `fr_o` inverts at the same base edge at which `vs_o` rises, and at no other time.
- R8: `buf_sel_i` (0 = buffer at address 0, 1 = buffer at address 9600) is sampled only at the base edge that starts the last period of a frame (line 159, group 59). The sampled value selects the buffer for the whole next frame. Changes at any other time have no effect on `data_o` or `rd_addr_o`.
- R9: `disp_buf_o` gives the buffer being shown. It changes only at the base edge that starts a frame's first period, one base cycle before `fr_o` flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| buf_sel_i | input | 1 | Buffer requested for the next frame |
| rd_addr_o | output | 15 | Frame-store byte address |
| rd_data_i | input | 8 | Frame-store byte, one cycle after address |
| pclk_o | output | 1 | Pixel clock to panel |
| data_o | output | 4 | Four pixels, bit 3 leftmost |
| hs_o | output | 1 | Line-latch pulse |
| vs_o | output | 1 | Frame-start pulse, one line long |
| fr_o | output | 1 | Frame polarity |
| disp_buf_o | output | 1 | Buffer currently displayed |

## Verification
The bench keeps its own count of base edges since reset and samples every output on the falling base edge. From that count it works out the period, group, line and phase, and from them the expected value of each port. The timing is fixed and the expected values follow from it:
- All timing outputs follow a base edge with no further delay. After edge k, `pclk_o`, `hs_o`, `vs_o` and `fr_o` already show the decode of phase k.
- A RAM byte addressed in period p reaches `data_o` at the first edge of period p+1, which is two base cycles after the address.
- A `buf_sel_i` value present at the sampling edge appears on `rd_addr_o` at that edge, on `disp_buf_o` two cycles later, and on `data_o` in the next frame.

Directed changes of `buf_sel_i` one cycle before and one cycle after the sampling edge show that the sample is taken at one edge only.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // default panel geometry and bus sizes
  localparam int DEF_H_PIX   = 240;
  localparam int DEF_V_LINES = 160;
  localparam int DEF_BUS_W   = 4;
  localparam int DEF_RD_W    = 8;

  // phase of one pixel period at the doubled base clock
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } half_e;
endpackage

// File: rtl/lcdt_scan.sv
module lcdt_scan #(
  parameter  int COLS = 60,
  parameter  int ROWS = 160,
  localparam int CW   = $clog2(COLS),
  localparam int LW   = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  adv,
  output lcdt_pkg::half_e       ph_n,
  output logic [CW-1:0]         col_n,
  output logic [LW-1:0]         line_n,
  output logic [CW-1:0]         col_a,
  output logic [LW-1:0]         line_a
);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [LW-1:0] ROW_LAST = LW'(ROWS - 1);

  lcdt_pkg::half_e ph_q;
  logic [CW-1:0]   col_q;
  logic [LW-1:0]   line_q;

  assign adv = (ph_q == lcdt_pkg::PH_LOW);

  // next position, and the position of the period after it
  always_comb begin
    ph_n   = (ph_q == lcdt_pkg::PH_LOW) ? lcdt_pkg::PH_HIGH : lcdt_pkg::PH_LOW;
    col_n  = col_q;
    line_n = line_q;
    if (adv) begin
      if (col_q == COL_LAST) begin
        col_n  = '0;
        line_n = (line_q == ROW_LAST) ? '0 : line_q + 1'b1;
      end else begin
        col_n = col_q + 1'b1;
      end
    end
    if (col_n == COL_LAST) begin
      col_a  = '0;
      line_a = (line_n == ROW_LAST) ? '0 : line_n + 1'b1;
    end else begin
      col_a  = col_n + 1'b1;
      line_a = line_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= lcdt_pkg::PH_HIGH;
      col_q  <= '0;
      line_q <= '0;
    end else begin
      ph_q   <= ph_n;
      col_q  <= col_n;
      line_q <= line_n;
    end
  end
endmodule

// File: rtl/lcdt_fetch.sv
module lcdt_fetch #(
  parameter  int COLS   = 60,
  parameter  int ROWS   = 160,
  parameter  int BUS_W  = 4,
  parameter  int RD_W   = 8,
  parameter  bit PIX_HI = 1'b0,
  localparam int CW     = $clog2(COLS),
  localparam int LW     = $clog2(ROWS),
  localparam int FRAME  = COLS * ROWS,
  localparam int AW     = $clog2(2 * FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CW-1:0]    col_n,
  input  logic [LW-1:0]    line_n,
  input  logic [CW-1:0]    col_a,
  input  logic [LW-1:0]    line_a,
  input  logic             buf_sel_i,
  input  logic [RD_W-1:0]  rd_data_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic [BUS_W-1:0] data_o,
  output logic             disp_buf_o
);
  logic             pend_q;
  logic             frame_start;
  logic             frame_last;
  logic             abuf;
  logic [AW-1:0]    offs;
  logic [BUS_W-1:0] pix;

  // entering group 0 of line 0; group after next is line 0 group 0
  assign frame_start = adv && (col_n == '0) && (line_n == '0);
  assign frame_last  = adv && (col_a == '0) && (line_a == '0);

  always_comb begin
    if (frame_last)       abuf = buf_sel_i;
    else if (frame_start) abuf = pend_q;
    else                  abuf = disp_buf_o;
  end

  assign offs = AW'(line_a) * AW'(COLS) + AW'(col_a);

  generate
    if (PIX_HI) begin : g_hi
      assign pix = rd_data_i[RD_W-1 -: BUS_W];
    end else begin : g_lo
      assign pix = rd_data_i[BUS_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      disp_buf_o <= 1'b0;
      rd_addr_o  <= AW'(1);
      data_o     <= '0;
    end else if (adv) begin
      if (frame_start) disp_buf_o <= pend_q;
      if (frame_last)  pend_q     <= buf_sel_i;
      rd_addr_o <= (abuf ? AW'(FRAME) : '0) + offs;
      data_o    <= pix;
    end
  end
endmodule

// File: rtl/lcdt_sync.sv
module lcdt_sync #(
  parameter  int COLS = 60,
  parameter  int ROWS = 160,
  localparam int CW   = $clog2(COLS),
  localparam int LW   = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  lcdt_pkg::half_e ph_n,
  input  logic [CW-1:0]   col_n,
  input  logic [LW-1:0]   line_n,
  output logic            pclk_o,
  output logic            hs_o,
  output logic            vs_o,
  output logic            fr_o
);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic lo_n;
  logic hs_d, vs_d, fr_flip;

  assign lo_n    = (ph_n == lcdt_pkg::PH_LOW);
  assign hs_d    = lo_n && (col_n == COL_LAST);
  assign vs_d    = ((line_n == '0) && ((col_n != '0) || lo_n)) ||
                   ((line_n == LW'(1)) && (col_n == '0) && !lo_n);
  assign fr_flip = lo_n && (col_n == '0) && (line_n == '0);

  // registered from the next state so outputs are glitch free
  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_o <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
      fr_o   <= 1'b0;
    end else begin
      pclk_o <= !lo_n;
      hs_o   <= hs_d;
      vs_o   <= vs_d;
      fr_o   <= fr_o ^ fr_flip;
    end
  end
endmodule

// File: rtl/lcd_mono_tgen.sv
module lcd_mono_tgen #(
  parameter  int H_PIX   = lcdt_pkg::DEF_H_PIX,
  parameter  int V_LINES = lcdt_pkg::DEF_V_LINES,
  parameter  int BUS_W   = lcdt_pkg::DEF_BUS_W,
  parameter  int RD_W    = lcdt_pkg::DEF_RD_W,
  parameter  bit PIX_HI  = 1'b0,
  localparam int COLS    = H_PIX / BUS_W,
  localparam int CW      = $clog2(COLS),
  localparam int LW      = $clog2(V_LINES),
  localparam int AW      = $clog2(2 * COLS * V_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             buf_sel_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [RD_W-1:0]  rd_data_i,
  output logic             pclk_o,
  output logic [BUS_W-1:0] data_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             fr_o,
  output logic             disp_buf_o
);
  logic            adv;
  lcdt_pkg::half_e ph_n;
  logic [CW-1:0]   col_n, col_a;
  logic [LW-1:0]   line_n, line_a;

  lcdt_scan #(.COLS(COLS), .ROWS(V_LINES)) u_scan (
    .clk(clk), .rst(rst), .adv(adv), .ph_n(ph_n),
    .col_n(col_n), .line_n(line_n), .col_a(col_a), .line_a(line_a)
  );

  lcdt_fetch #(.COLS(COLS), .ROWS(V_LINES), .BUS_W(BUS_W), .RD_W(RD_W),
               .PIX_HI(PIX_HI)) u_fetch (
    .clk(clk), .rst(rst), .adv(adv),
    .col_n(col_n), .line_n(line_n), .col_a(col_a), .line_a(line_a),
    .buf_sel_i(buf_sel_i), .rd_data_i(rd_data_i),
    .rd_addr_o(rd_addr_o), .data_o(data_o), .disp_buf_o(disp_buf_o)
  );

  lcdt_sync #(.COLS(COLS), .ROWS(V_LINES)) u_sync (
    .clk(clk), .rst(rst), .ph_n(ph_n), .col_n(col_n), .line_n(line_n),
    .pclk_o(pclk_o), .hs_o(hs_o), .vs_o(vs_o), .fr_o(fr_o)
  );
endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk #(
  parameter int BUS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pclk_o,
  input logic [BUS_W-1:0] data_o,
  input logic             hs_o,
  input logic             vs_o,
  input logic             fr_o,
  input logic             disp_buf_o
);
  // R2
  pclk_alt_chk: assert property (@(posedge clk) disable iff (rst)
    pclk_o |=> !pclk_o);

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> pclk_o);

  // R5
  hs_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    hs_o |=> !hs_o);

  // R5
  hs_low_chk: assert property (@(posedge clk) disable iff (rst)
    hs_o |-> !pclk_o);

  // R6
  vs_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_o) |-> !pclk_o);

  // R7
  fr_flip_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fr_o) |-> $rose(vs_o));

  // R9
  buf_swap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(disp_buf_o) |=> !$stable(fr_o));
endmodule

bind lcd_mono_tgen lcdt_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .pclk_o(pclk_o), .data_o(data_o), .hs_o(hs_o),
  .vs_o(vs_o), .fr_o(fr_o), .disp_buf_o(disp_buf_o)
);

// File: tb/sim_lcd_mono_tgen.sv
`timescale 1ns/1ps
module sim_lcd_mono_tgen;
  localparam int COLS   = 60;
  localparam int ROWS   = 160;
  localparam int FPER   = COLS * ROWS;
  localparam int FCYC   = 2 * FPER;
  localparam int RUN    = 4 * FCYC + 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        buf_sel = 1'b0;
  logic [14:0] rd_addr;
  logic [7:0]  rd_data;
  logic        pclk, hs, vs, fr, dbuf;
  logic [3:0]  data;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  k = 0;
  bit  cur_buf = 1'b0;
  bit  pend = 1'b0;
  bit  chk_on = 1'b0;
  bit  done = 1'b0;
  int  salt = 0;

  lcd_mono_tgen u0 (
    .clk(clk), .rst(rst), .buf_sel_i(buf_sel), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .pclk_o(pclk), .data_o(data), .hs_o(hs),
    .vs_o(vs), .fr_o(fr), .disp_buf_o(dbuf)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] ram_f(int a);
    logic [31:0] h;
    h = (a * 40503) ^ salt;
    return h[15:8] ^ h[7:0];
  endfunction

  // frame store model: synchronous read, one cycle latency
  always @(posedge clk) rd_data <= ram_f(int'(rd_addr));

  // bench copy of the scan position and the buffer choice
  always @(posedge clk) begin
    if (rst) begin
      k <= 0; cur_buf <= 1'b0; pend <= 1'b0;
    end else begin
      k <= k + 1;
      if ((k + 1) % FCYC == FCYC - 2) pend <= buf_sel;
      if ((k + 1) % FCYC == 0) cur_buf <= pend;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at k=%0d: actual=%0d expected=%0d", tag, k, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      int ph, p, col, ln, q, qb, e_vs;
      ph  = k % 2;
      p   = k / 2;
      col = p % COLS;
      ln  = (p / COLS) % ROWS;
      q   = p + 1;
      qb  = ((q % FPER) == 0) ? int'(pend) : int'(cur_buf);
      if (k == 0) begin
        // R1 reset state
        chk("R1 pclk", int'(pclk), 0);
        chk("R1 data", int'(data), 0);
        chk("R1 hs", int'(hs), 0);
        chk("R1 vs", int'(vs), 0);
        chk("R1 fr", int'(fr), 0);
        chk("R1 addr", int'(rd_addr), 1);
      end else begin
        chk("R2 pclk", int'(pclk), (ph == 0) ? 1 : 0);
        chk("R5 hs", int'(hs), (ph == 1 && col == COLS - 1) ? 1 : 0);
        e_vs = ((ln == 0 && (col != 0 || ph == 1)) ||
                (ln == 1 && col == 0 && ph == 0)) ? 1 : 0;
        chk("R6 vs", int'(vs), e_vs);
        chk("R7 fr", int'(fr), (((k - 1) / FCYC) + 1) % 2);
      end
      if (p == 0) chk("R3 data first", int'(data), 0);
      else if (p < FPER)
        chk("R3 data", int'(data),
            int'(ram_f(int'(cur_buf) * FPER + ln * COLS + col) & 8'h0F));
      else
        chk("R8 data", int'(data),
            int'(ram_f(int'(cur_buf) * FPER + ln * COLS + col) & 8'h0F));
      chk("R4 addr", int'(rd_addr), qb * FPER + ((q / COLS) % ROWS) * COLS + q % COLS);
      chk("R9 dispbuf", int'(dbuf), int'(cur_buf));
    end
  end

  initial begin
    salt = int'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    chk_on = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      if (k == FCYC - 3) buf_sel = 1'b1;                    // R8 set just before sample
      else if (k == 2 * FCYC - 2) buf_sel = 1'b0;           // R8 change just after sample
      else if (k == 3 * FCYC - 3) buf_sel = 1'b1;           // R8 taken at next sample
      else if (k > 3 * FCYC && ($urandom % 3000) == 0) buf_sel = ~buf_sel;
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 120000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule